// File: doc/BRIEF.md
# Packed Byte Permute and Saturate Unit

This block rearranges and narrows 32-bit data held as packed bytes and halfwords. It takes two 32-bit operands, A and B, and a 4-bit operation select. It returns one 32-bit result. Twelve operations share a single output register:

- four halfword pack variants;
- byte shift-and-merge, left and right;
- a swap of the two halfwords;
- a byte swap inside each halfword;
- zero-extending unpack of the upper or the lower byte pair;
- two saturating narrowing modes.

Operations that take one operand read B and ignore A.

The datapath is combinational. One register stage follows it. An input strobe travels with the operands, so each accepted operation appears on the output one clock later with its own valid flag. An unassigned operation code gives a zero result and raises a one-cycle illegal flag. Surrounding logic can then trap the bad code.

Top module: `pbp_unit`

## Requirements
- R1: Op codes 0..3 pack halfwords. Code 0 gives {A[31:16], B[15:0]}, code 1 gives {A[15:0], B[31:16]}, code 2 gives {A[31:16], B[31:16]} and code 3 gives {A[15:0], B[15:0]}.
- R2: Op code 4 shifts B left by one byte and puts A[31:24] into the vacated low byte.
- R3: Op code 5 shifts B right by one byte and puts A[7:0] into the vacated top byte.
- R4: Op code 6 exchanges the two 16-bit halves of B.
- R5: Op code 7 exchanges the two bytes inside each 16-bit half of B.
- R6: Op code 8 zero-extends B[31:24] into bits 31:16 and B[23:16] into bits 15:0. Op code 9 does the same for B[15:8] and B[7:0].
- R7: Op code 10 clamps A and B, each read as a signed 32-bit value, to the range -32768..32767. A goes to the upper half of the result and B to the lower half.
- R8: Op code 11 reads the four signed 16-bit halves A[31:16], A[15:0], B[31:16] and B[15:0]. Each is clamped to 0..255 and placed from the top byte down in that order.
- R9: The result, valid_o and illegal_o appear on the clock edge after valid_i is sampled high. valid_o is the previous cycle's valid_i.
- R10: While valid_i is low, result_o holds its value and operand changes have no effect.
- R11: An accepted op code in 12..15 gives result 0 with illegal_o high for that one output cycle.
- R12: An active-low asynchronous reset clears result_o, valid_o and illegal_o.
- R13: Ops 6 to 9 give the same result whatever the value of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and op code are valid this cycle |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Registered result |
| illegal_o | output | 1 | Registered flag for an unassigned op code |

## Verification
All operand-reading ops are first driven with one shared operand pair whose bytes are all distinct. A misrouted byte or halfword in any pack, merge or swap then yields a visibly different word. Single-operand ops are repeated with a different A, which shows that A is never read. The saturating modes are driven with values above the limit, below the limit and exactly at it: 255 against 256, the exact minimum of -32768, and -32769. These separate correct clamping from an off-by-one or an unsigned compare. Back-to-back ops, idle cycles with changing operands, illegal codes and a reset in mid-run show the latency, the hold behaviour and the flag timing.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PACK_HL = 4'd0,
    OP_PACK_LH = 4'd1,
    OP_PACK_HH = 4'd2,
    OP_PACK_LL = 4'd3,
    OP_SHL_MRG = 4'd4,
    OP_SHR_MRG = 4'd5,
    OP_SWAP_HW = 4'd6,
    OP_SWAP_BY = 4'd7,
    OP_UNPK_HI = 4'd8,
    OP_UNPK_LO = 4'd9,
    OP_SAT_S16 = 4'd10,
    OP_SAT_U8  = 4'd11
  } pbp_op_e;
endpackage

// File: rtl/pbp_perm.sv
module pbp_perm
  import pbp_pkg::*;
(
  input  pbp_op_e           op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] res_o,
  output logic              hit_o
);
  localparam int unsigned NB = WORD_W / BYTE_W;

  logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [WORD_W-1:0] b_bswap;

  assign a_hi = a_i[WORD_W-1:HALF_W];
  assign a_lo = a_i[HALF_W-1:0];
  assign b_hi = b_i[WORD_W-1:HALF_W];
  assign b_lo = b_i[HALF_W-1:0];

  // byte swap inside each halfword
  for (genvar g = 0; g < NB; g++) begin : g_bswap
    localparam int unsigned SRC = g ^ 1;
    assign b_bswap[g*BYTE_W +: BYTE_W] = b_i[SRC*BYTE_W +: BYTE_W];
  end

  always_comb begin
    hit_o = 1'b1;
    res_o = '0;
    case (op_i)
      OP_PACK_HL: res_o = {a_hi, b_lo};
      OP_PACK_LH: res_o = {a_lo, b_hi};
      OP_PACK_HH: res_o = {a_hi, b_hi};
      OP_PACK_LL: res_o = {a_lo, b_lo};
      OP_SHL_MRG: res_o = {b_i[WORD_W-BYTE_W-1:0], a_i[WORD_W-1 -: BYTE_W]};
      OP_SHR_MRG: res_o = {a_i[BYTE_W-1:0], b_i[WORD_W-1:BYTE_W]};
      OP_SWAP_HW: res_o = {b_lo, b_hi};
      OP_SWAP_BY: res_o = b_bswap;
      OP_UNPK_HI: res_o = {{(HALF_W-BYTE_W){1'b0}}, b_hi[HALF_W-1 -: BYTE_W],
                           {(HALF_W-BYTE_W){1'b0}}, b_hi[BYTE_W-1:0]};
      OP_UNPK_LO: res_o = {{(HALF_W-BYTE_W){1'b0}}, b_lo[HALF_W-1 -: BYTE_W],
                           {(HALF_W-BYTE_W){1'b0}}, b_lo[BYTE_W-1:0]};
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pbp_sat.sv
module pbp_sat
  import pbp_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] s16_o,
  output logic [WORD_W-1:0] u8_o
);
  localparam int unsigned NW = 2;
  localparam int unsigned NH = WORD_W / HALF_W * NW;

  logic [NW*WORD_W-1:0] words;
  assign words = {a_i, b_i};

  // signed word -> signed halfword
  for (genvar w = 0; w < NW; w++) begin : g_s16
    logic signed [WORD_W-1:0] v;
    logic                     ovf_hi, ovf_lo;
    assign v      = $signed(words[w*WORD_W +: WORD_W]);
    assign ovf_hi = v > $signed({{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}});
    assign ovf_lo = v < $signed({{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}});
    assign s16_o[w*HALF_W +: HALF_W] =
        ovf_hi ? {1'b0, {(HALF_W-1){1'b1}}} :
        ovf_lo ? {1'b1, {(HALF_W-1){1'b0}}} : v[HALF_W-1:0];
  end

  // signed halfword -> unsigned byte
  for (genvar h = 0; h < NH; h++) begin : g_u8
    logic [HALF_W-1:0] hv;
    logic              neg, big;
    assign hv  = words[h*HALF_W +: HALF_W];
    assign neg = hv[HALF_W-1];
    assign big = |hv[HALF_W-2:BYTE_W];
    assign u8_o[h*BYTE_W +: BYTE_W] =
        neg ? '0 : big ? '1 : hv[BYTE_W-1:0];
  end
endmodule

// File: rtl/pbp_unit.sv
module pbp_unit
  import pbp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic              illegal_o
);
  pbp_op_e           op;
  logic [WORD_W-1:0] perm_res, s16_res, u8_res, nxt_res;
  logic              perm_hit, nxt_ill;

  assign op = pbp_op_e'(op_i);

  pbp_perm u_perm (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (perm_res),
    .hit_o (perm_hit)
  );

  pbp_sat u_sat (
    .a_i   (a_i),
    .b_i   (b_i),
    .s16_o (s16_res),
    .u8_o  (u8_res)
  );

  always_comb begin
    nxt_ill = 1'b0;
    nxt_res = '0;
    if (perm_hit)              nxt_res = perm_res;
    else if (op == OP_SAT_S16) nxt_res = s16_res;
    else if (op == OP_SAT_U8)  nxt_res = u8_res;
    else                       nxt_ill = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i & nxt_ill;
      if (valid_i) result_o <= nxt_res;
    end
  end
endmodule

// File: rtl/pbp_unit_chk.sv
module pbp_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [3:0]  op_i,
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic        valid_o,
  input logic [31:0] result_o,
  input logic        illegal_o
);
  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  p_illegal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 4'd12) |=> (illegal_o && result_o == 32'h0));
  p_illegal_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> valid_o);
  p_hw_swap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd6) |=> result_o == {$past(b_i[15:0]), $past(b_i[31:16])});
  p_unpk_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd8 || op_i == 4'd9)) |=>
      (result_o[31:24] == 8'h0 && result_o[15:8] == 8'h0));
  p_s16_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd10 && $signed(a_i) > 32'sd32767) |=>
      result_o[31:16] == 16'h7fff);
  p_u8_neg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd11 && a_i[31]) |=> result_o[31:24] == 8'h00);
endmodule

bind pbp_unit pbp_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/pbp_unit_test.sv
`timescale 1ns/1ps
module pbp_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        valid_o, illegal_o;
  logic [31:0] result_o;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [31:0] OPA = 32'h3789F23A;
  localparam logic [31:0] OPB = 32'h04B84975;

  always #5 clk_i = ~clk_i;

  pbp_unit uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a negedge, sample at the following negedge
  task automatic run_op(input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] exp,
                        input string tag);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    check(result_o == exp, tag, result_o, exp);
    check(valid_o == 1'b1 && illegal_o == 1'b0, {tag, " flags"},
          {30'b0, valid_o, illegal_o}, 32'h2);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check(result_o == 0 && !valid_o && !illegal_o, "R12 reset state",
          result_o | {valid_o, illegal_o}, 32'h0);
  endtask

  task automatic t_pack;
    run_op(4'd0, OPA, OPB, 32'h37894975, "R1 pack hl");
    run_op(4'd1, OPA, OPB, 32'hF23A04B8, "R1 pack lh");
    run_op(4'd2, OPA, OPB, 32'h378904B8, "R1 pack hh");
    run_op(4'd3, OPA, OPB, 32'hF23A4975, "R1 pack ll");
  endtask

  task automatic t_merge;
    run_op(4'd4, OPA, OPB, 32'hB8497537, "R2 shl merge");
    run_op(4'd5, OPA, OPB, 32'h3A04B849, "R3 shr merge");
  endtask

  task automatic t_swap_unpack;
    run_op(4'd6, 32'h0, 32'h3789F23A, 32'hF23A3789, "R4 half swap");
    run_op(4'd7, 32'h0, 32'h9E526E30, 32'h529E306E, "R5 byte swap");
    run_op(4'd8, 32'h0, 32'h9E526E30, 32'h009E0052, "R6 unpack hi");
    run_op(4'd9, 32'h0, 32'h11056934, 32'h00690034, "R6 unpack lo");
  endtask

  task automatic t_a_ignored;
    run_op(4'd6, 32'hDEADBEEF, 32'h3789F23A, 32'hF23A3789, "R13 swap hw A ignored");
    run_op(4'd7, 32'hFFFFFFFF, 32'h9E526E30, 32'h529E306E, "R13 swap by A ignored");
    run_op(4'd9, 32'hA5A5A5A5, 32'h11056934, 32'h00690034, "R13 unpack A ignored");
  endtask

  task automatic t_sat16;
    run_op(4'd10, OPA, OPB, 32'h7FFF7FFF, "R7 sat16 high");
    run_op(4'd10, 32'hFFFF8000, 32'h00001234, 32'h80001234, "R7 sat16 min exact");
    run_op(4'd10, 32'hFFFF7FFF, 32'h80000000, 32'h80008000, "R7 sat16 low clamp");
  endtask

  task automatic t_satu8;
    run_op(4'd11, OPA, OPB, 32'hFF00FFFF, "R8 satu8 mix");
    run_op(4'd11, 32'h00FF0100, 32'hFFFF0042, 32'hFFFF0042, "R8 satu8 bounds");
  endtask

  task automatic t_b2b;
    valid_i = 1'b1; op_i = 4'd0; a_i = OPA; b_i = OPB;
    @(negedge clk_i);
    check(result_o == 32'h37894975, "R9 b2b first", result_o, 32'h37894975);
    op_i = 4'd1;
    @(negedge clk_i);
    check(result_o == 32'hF23A04B8, "R9 b2b second", result_o, 32'hF23A04B8);
    valid_i = 1'b0;
    @(negedge clk_i);
    check(valid_o == 1'b0, "R9 valid drops", {31'b0, valid_o}, 32'h0);
  endtask

  task automatic t_hold;
    run_op(4'd4, OPA, OPB, 32'hB8497537, "R10 setup");
    op_i = 4'd6; a_i = 32'h12345678; b_i = 32'h9ABCDEF0;
    repeat (2) @(negedge clk_i);
    check(result_o == 32'hB8497537 && !valid_o, "R10 hold while idle",
          result_o, 32'hB8497537);
  endtask

  task automatic t_illegal;
    valid_i = 1'b1; op_i = 4'd12; a_i = OPA; b_i = OPB;
    @(negedge clk_i);
    check(result_o == 0 && illegal_o && valid_o, "R11 op 12",
          result_o | {illegal_o, valid_o}, 32'h3);
    op_i = 4'd15;
    @(negedge clk_i);
    check(result_o == 0 && illegal_o, "R11 op 15",
          result_o | {illegal_o, 1'b0}, 32'h2);
    valid_i = 1'b0;
    @(negedge clk_i);
    check(!illegal_o, "R11 flag lasts one cycle", {31'b0, illegal_o}, 32'h0);
  endtask

  task automatic t_mid_reset;
    run_op(4'd0, OPA, OPB, 32'h37894975, "R12 setup");
    #2 rst_ni = 1'b0;
    #1 check(result_o == 0 && !valid_o, "R12 async reset",
             result_o | {31'b0, valid_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_pack();
    t_merge();
    t_swap_unpack();
    t_a_ignored();
    t_sat16();
    t_satu8();
    t_b2b();
    t_hold();
    t_illegal();
    t_mid_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule